// File: doc/BRIEF.md
# Token-Gated Accumulator Wrapper

This block lets a small synchronous target circuit run inside a host-clocked system that moves data as tokens. The target is an accumulator, included for testing. The target takes one step only in a host cycle where every input channel offers a token and every output channel can take one. That condition is the fire signal. The fire signal acts as a clock enable on every target register, so the target never sees a gated clock net.

Each neighbour of the target is reached through one ready/valid channel per direction. Input channels are always ready: a token is consumed exactly in the cycle where fire is high. Output channels present a token in that same cycle. The token's bits are computed combinationally from the current target state and the input tokens being consumed. The target's clock is not carried on any channel. Host reset is synchronous and active high. It clears the target and keeps fire low for as long as it is asserted.

The target steps through two named conditions, HOLD and STEP. HOLD applies when fire is low and STEP when fire is high. The transition is re-evaluated on every host edge.

Top module: `tokwrap_top`

## Requirements
- R1: `out_valid` on every output channel equals the fire condition. Fire is high exactly when `rst` is low, every bit of `in_valid` is 1 and every bit of `out_ready` is 1, all in the same host cycle.
- R2: Every bit of `in_ready` is 1 in every cycle, including cycles with reset asserted.
- R3: On a host edge where fire is high, the accumulator becomes (accumulator + sum of all input channel words) mod 2^W.
- R4: When fire is low, the accumulator keeps its value for any number of host cycles. This is observed through the bits of the next fired output token.
- R5: While fire is high, output channel j carries (accumulator + sum of input words + j) mod 2^W in that same cycle.
- R6: A host edge with `rst` high clears the accumulator to 0, and `out_valid` is 0 while `rst` is high, whatever the channel inputs are.
- R7: Input channel i occupies `in_bits[i*W +: W]`, and output channel j occupies `out_bits[j*W +: W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high host reset |
| in_valid | input | N_IN | Token offered on each input channel |
| in_ready | output | N_IN | Input channel can accept a token (constant 1) |
| in_bits | input | N_IN*W | Packed input channel words |
| out_valid | output | N_OUT | Token presented on each output channel |
| out_ready | input | N_OUT | Output channel can accept a token |
| out_bits | output | N_OUT*W | Packed output channel words |

## Verification
The bench builds the block with three input channels, two output channels and an 8-bit word. The odd input count means the fire reduction and the word sum are not over a power-of-two width. The narrow word makes the accumulator wrap many times within a few thousand cycles. Random valid and ready stalls are checked against a behavioural model. The model advances only when the bench's own fire prediction is true, so long holds, back-to-back fires, and a reset asserted while all tokens are present are all exercised.

// File: rtl/tokwrap_pkg.sv
package tokwrap_pkg;
    typedef enum logic {
        TGT_HOLD = 1'b0,
        TGT_STEP = 1'b1
    } tgt_step_e;
endpackage

// File: rtl/tokwrap_fire.sv
module tokwrap_fire #(
    parameter int N_IN  = 2,
    parameter int N_OUT = 2
) (
    input  logic             rst,
    input  logic [N_IN-1:0]  in_valid,
    input  logic [N_OUT-1:0] out_ready,
    output logic             fire
);
    logic all_in;
    logic all_out;

    always_comb begin
        all_in  = &in_valid;
        all_out = &out_ready;
        fire    = !rst && all_in && all_out;
    end
endmodule

// File: rtl/tokwrap_accum.sv
module tokwrap_accum
    import tokwrap_pkg::*;
#(
    parameter int N_IN  = 2,
    parameter int N_OUT = 2,
    parameter int W     = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fire,
    input  logic [N_IN*W-1:0]  in_bits,
    output logic [N_OUT*W-1:0] out_bits
);
    logic [W-1:0] acc_q;
    logic [W-1:0] in_sum;
    logic [W-1:0] acc_next;
    tgt_step_e    step;

    always_comb begin
        in_sum = '0;
        for (int i = 0; i < N_IN; i++) begin
            in_sum = in_sum + in_bits[i*W +: W];
        end
        acc_next = acc_q + in_sum;
        step     = fire ? TGT_STEP : TGT_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            unique case (step)
                TGT_HOLD: acc_q <= acc_q;
                TGT_STEP: acc_q <= acc_next;
            endcase
        end
    end

    for (genvar j = 0; j < N_OUT; j++) begin : g_out
        localparam logic [W-1:0] OFS = W'(j);
        assign out_bits[j*W +: W] = acc_next + OFS;
    end

    // R4: no step means the stored value is untouched
    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(acc_q));
    // R3: a step lands the pre-edge next value
    assert_step_R3: assert property (@(posedge clk) disable iff (rst)
        fire |=> acc_q == $past(acc_next));
    // R6: reset clears the target
    assert_clear_R6: assert property (@(posedge clk)
        rst |=> acc_q == '0);
endmodule

// File: rtl/tokwrap_top.sv
module tokwrap_top #(
    parameter int N_IN  = 2,
    parameter int N_OUT = 2,
    parameter int W     = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_IN-1:0]    in_valid,
    output logic [N_IN-1:0]    in_ready,
    input  logic [N_IN*W-1:0]  in_bits,
    output logic [N_OUT-1:0]   out_valid,
    input  logic [N_OUT-1:0]   out_ready,
    output logic [N_OUT*W-1:0] out_bits
);
    logic fire;

    tokwrap_fire #(.N_IN(N_IN), .N_OUT(N_OUT)) u_fire (
        .rst       (rst),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .fire      (fire)
    );

    tokwrap_accum #(.N_IN(N_IN), .N_OUT(N_OUT), .W(W)) u_tgt (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire),
        .in_bits  (in_bits),
        .out_bits (out_bits)
    );

    for (genvar i = 0; i < N_IN; i++) begin : g_in
        assign in_ready[i] = 1'b1;
    end

    for (genvar j = 0; j < N_OUT; j++) begin : g_ov
        assign out_valid[j] = fire;
    end

    // R1: a token leaves only when all inputs and all outputs agree
    assert_valid_gate_R1: assert property (@(posedge clk) disable iff (rst)
        (|out_valid) |-> ((&in_valid) && (&out_ready)));
    // R1: all output channels fire together
    assert_valid_same_R1: assert property (@(posedge clk) disable iff (rst)
        (out_valid == '0) || (out_valid == '1));
    // R6: no token presented while reset is held
    assert_rst_quiet_R6: assert property (@(posedge clk)
        rst |-> (out_valid == '0));
endmodule

// File: tb/sim_tokwrap_top.sv
module sim_tokwrap_top;
    localparam int NI = 3;
    localparam int NO = 2;
    localparam int W  = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst = 1'b1;
    logic [NI-1:0]   in_valid = '0;
    logic [NI-1:0]   in_ready;
    logic [NI*W-1:0] in_bits = '0;
    logic [NO-1:0]   out_valid;
    logic [NO-1:0]   out_ready = '0;
    logic [NO*W-1:0] out_bits;

    tokwrap_top #(.N_IN(NI), .N_OUT(NO), .W(W)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_bits(in_bits), .out_valid(out_valid), .out_ready(out_ready),
        .out_bits(out_bits)
    );

    int checks = 0;
    int fails  = 0;
    int model_acc = 0;
    bit done = 1'b0;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one host cycle: drive after falling edge, compare before rising edge
    task automatic cyc(string tag, bit r, logic [NI-1:0] v, logic [NO-1:0] rd,
                       logic [NI*W-1:0] b);
        int sum;
        bit f;
        @(negedge clk);
        rst = r; in_valid = v; out_ready = rd; in_bits = b;
        #1;
        f = !r && (&v) && (&rd);
        sum = 0;
        for (int i = 0; i < NI; i++) sum += int'(b[i*W +: W]);
        for (int j = 0; j < NO; j++) chk("R1 out_valid", int'(out_valid[j]), int'(f));
        chk("R2 in_ready", int'(in_ready), (1 << NI) - 1);
        if (f) begin
            for (int j = 0; j < NO; j++)
                chk(tag, int'(out_bits[j*W +: W]), (model_acc + sum + j) % (1 << W));
        end
        if (r) model_acc = 0;
        else if (f) model_acc = (model_acc + sum) % (1 << W);
    endtask

    function automatic logic [NI*W-1:0] rnd_bits();
        logic [NI*W-1:0] x;
        for (int i = 0; i < NI; i++) x[i*W +: W] = W'($urandom);
        return x;
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        // R6: reset, including a cycle where all tokens are offered
        cyc("R6", 1'b1, '0, '0, '0);
        cyc("R6", 1'b1, '1, '1, rnd_bits());
        cyc("R6", 1'b1, '1, '1, '0);
        // R6: first fire after reset shows a cleared accumulator
        cyc("R6 cleared", 1'b0, '1, '1, '0);
        // R7: distinct words per input channel
        cyc("R7 packing", 1'b0, '1, '1, {8'd4, 8'd2, 8'd1});
        cyc("R7 packing", 1'b0, '1, '1, {8'd64, 8'd32, 8'd16});
        // R4: long stall with tokens missing on one side, then fire
        for (int k = 0; k < 25; k++)
            cyc("R4 hold", 1'b0, 3'b101, '1, rnd_bits());
        for (int k = 0; k < 25; k++)
            cyc("R4 hold", 1'b0, '1, 2'b10, rnd_bits());
        cyc("R4 hold", 1'b0, '1, '1, {8'd0, 8'd0, 8'd5});
        // R3: wrap-around with back-to-back fires
        for (int k = 0; k < 20; k++)
            cyc("R3 wrap", 1'b0, '1, '1, {8'd255, 8'd200, 8'd100});
        // R5: random stalls on both sides
        for (int k = 0; k < 3000; k++) begin
            logic [NI-1:0] v;
            logic [NO-1:0] rd;
            for (int i = 0; i < NI; i++) v[i] = ($urandom % 4) != 0;
            for (int j = 0; j < NO; j++) rd[j] = ($urandom % 4) != 0;
            cyc("R5 random", ($urandom % 500) == 0, v, rd, rnd_bits());
        end
        // R6: reset mid-run, then verify cleared
        cyc("R6", 1'b1, '1, '1, rnd_bits());
        cyc("R6 cleared", 1'b0, '1, '1, {8'd0, 8'd0, 8'd9});
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule